// File: doc/BRIEF.md
# Selectable Clock Divider with Source Bypass

This block derives a divided clock from one of two sources: a reference clock, or the clock of an upstream frequency synthesizer, which is modelled here as a plain input. A source-select input picks between them. A glitch-free switch gates exactly one source onto an internal divider clock. A 4-bit ratio code picks a power-of-two division ratio between 1 and 64 through a fixed lookup. The lookup is not monotonic in the code, and several codes share a ratio.

The divided clock drives two mirrored output pairs. One pair is the main output and the other is a feedback copy for a phase comparator. Each pair has a true line and a complement line. New ratio codes and source selections take effect only at the end of a full output period (the end of a low phase), so that no runt pulse appears. A synchronous active-low reset clears the divider and holds both true outputs low and both complements high.

Top module: `clkdiv_sel`

## Requirements
- R1: With `use_pll` = 0 the outputs are divided from `ref_clk`; with `use_pll` = 1 they are divided from `pll_clk`.
- R2: The ratio for `ratio_code` values 0..15 (bit 3 is the most significant bit) is 4, 4, 4, 8, 8, 8, 16, 16, 32, 64, 2, 2, 4, 1, 2, 1. The same table applies to both sources.
- R3: At ratio 1 the outputs pass the selected source clock through, so the output period and high time equal those of the source.
- R4: At every ratio N ≥ 2 the true output toggles once every N/2 selected-clock rising edges. This gives a period of N source cycles at 50 % duty.
- R5: `out_fb` always equals `out_main`, `out_fb_b` equals `out_main_b`, and each complement is the inverse of its true line.
- R6: While `rst_n` is low (sampled on the selected clock), the divider count is zero, `out_main` and `out_fb` are low, and `out_main_b` and `out_fb_b` are high.
- R7: After `rst_n` is released at a ratio N ≥ 2, the true outputs first rise on the (N/2)-th selected-clock rising edge that samples `rst_n` high.
- R8: A change of `ratio_code` is taken up only at the end of a low phase. The high phase and low phase already in progress both complete at the old length.
- R9: A change of `use_pll` is applied at the end of a low phase. The switch never gates both sources onto the divider clock at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, bypass source |
| pll_clk | input | 1 | Synthesizer clock source |
| rst_n | input | 1 | Synchronous active-low reset of the divider |
| use_pll | input | 1 | Source select: 0 reference, 1 synthesizer |
| ratio_code | input | 4 | Division ratio code (see R2) |
| out_main | output | 1 | Main divided clock, true line |
| out_main_b | output | 1 | Main divided clock, complement line |
| out_fb | output | 1 | Feedback copy, true line |
| out_fb_b | output | 1 | Feedback copy, complement line |

## Verification
The assertions assume that both source clocks run freely, so that the switch handshake can complete. They also assume that `rst_n` stays low for several cycles of the selected clock. The assertions further assume that `rst_n`, `ratio_code` and `use_pll` change well away from the selected clock's rising edges, because they are sampled in the divider clock domain without synchronisers. The stimulus holds reset low for at least ten reference cycles. It changes every control input only at a falling edge of the reference clock or a fixed delay after an output edge, so no control input moves near a sampling edge.

// File: rtl/clkdiv_pkg.sv
// Shared constants and the ratio-code decode for the selectable clock divider.
// Assumes ratios are powers of two and are stored as their base-2 logarithm.
package clkdiv_pkg;

    localparam int unsigned CODE_W   = 4;
    localparam int unsigned MAX_LOG2 = 6;
    localparam int unsigned LOG2_W   = $clog2(MAX_LOG2 + 1);
    localparam int unsigned CNT_W    = (MAX_LOG2 > 1) ? MAX_LOG2 - 1 : 1;

    // Map a ratio code to log2 of its division ratio (non-monotonic table).
    function automatic logic [LOG2_W-1:0] code_to_log2(input logic [CODE_W-1:0] code);
        logic [LOG2_W-1:0] l2;
        case (code)
            4'd0, 4'd1, 4'd2:  l2 = LOG2_W'(2);
            4'd3, 4'd4, 4'd5:  l2 = LOG2_W'(3);
            4'd6, 4'd7:        l2 = LOG2_W'(4);
            4'd8:              l2 = LOG2_W'(5);
            4'd9:              l2 = LOG2_W'(6);
            4'd10, 4'd11:      l2 = LOG2_W'(1);
            4'd12:             l2 = LOG2_W'(2);
            4'd14:             l2 = LOG2_W'(1);
            default:           l2 = LOG2_W'(0);
        endcase
        return l2;
    endfunction

endpackage

// File: rtl/clkdiv_switch.sv
// Glitch-free two-source clock switch.
// Each source owns an arm flop (rising edge) and a live flop (falling edge). A
// source is armed only while the other one is not live, so the two gates never
// overlap. Needs no reset: from any start state the unselected side drops within
// one of its cycles and the selected side then starts. Assumes both clocks run.
module clkdiv_switch (
    input  logic ref_clk,
    input  logic pll_clk,
    input  logic sel_pll,
    output logic div_clk,
    output logic ref_live,
    output logic pll_live
);

    logic ref_arm_q, ref_live_q;
    logic pll_arm_q, pll_live_q;

    // Arm the reference side when it is wanted and the other side is idle.
    always_ff @(posedge ref_clk) begin
        ref_arm_q <= ~sel_pll & ~pll_live_q;
    end

    // Open or close the reference gate while the reference clock is low.
    always_ff @(negedge ref_clk) begin
        ref_live_q <= ref_arm_q;
    end

    // Arm the synthesizer side when it is wanted and the other side is idle.
    always_ff @(posedge pll_clk) begin
        pll_arm_q <= sel_pll & ~ref_live_q;
    end

    // Open or close the synthesizer gate while its clock is low.
    always_ff @(negedge pll_clk) begin
        pll_live_q <= pll_arm_q;
    end

    // Combine the gated sources into the divider clock.
    always_comb begin
        div_clk = (ref_clk & ref_live_q) | (pll_clk & pll_live_q);
    end

    assign ref_live = ref_live_q;
    assign pll_live = pll_live_q;

endmodule

// File: rtl/clkdiv_engine.sv
// Divider engine on the switched clock.
// Holds the applied ratio and source, a half-period counter and the toggle flop.
// Takes up new ratio and source values only at a period boundary (the end of a
// low phase) or during reset. Ratio 1 is served by a pass-through enable that
// changes on the falling edge, so that switching the path never clips a pulse.
// Assumes rst_n and the controls are stable around rising edges of div_clk.
module clkdiv_engine #(
    parameter int unsigned CODE_W = clkdiv_pkg::CODE_W,
    parameter int unsigned LOG2_W = clkdiv_pkg::LOG2_W,
    parameter int unsigned CNT_W  = clkdiv_pkg::CNT_W
) (
    input  logic              div_clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              use_pll,
    output logic              sel_pll,
    output logic [LOG2_W-1:0] log2_app,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  half_m1,
    output logic              boundary,
    output logic              tog,
    output logic              pass
);

    logic [LOG2_W-1:0] log2_q;
    logic [LOG2_W-1:0] log2_next;
    logic [CNT_W-1:0]  cnt_q;
    logic              tog_q;
    logic              sel_q;
    logic              run_q;
    logic              pass_q;
    logic              bypass_now;

    // Decode the requested ratio code.
    always_comb begin
        log2_next = clkdiv_pkg::code_to_log2(ratio_code);
    end

    // Terminal count of a half period for the applied ratio.
    always_comb begin
        half_m1 = '0;
        if (log2_q != '0) begin
            half_m1 = CNT_W'((32'd1 << (log2_q - LOG2_W'(1))) - 32'd1);
        end
    end

    // A period ends each cycle at ratio 1, else at the last count of a low phase.
    always_comb begin
        bypass_now = (log2_q == '0);
        boundary   = bypass_now || (!tog_q && (cnt_q == half_m1));
    end

    // Load the applied ratio and source in reset or at a period boundary.
    always_ff @(posedge div_clk) begin
        if (!rst_n || boundary) begin
            log2_q <= log2_next;
            sel_q  <= use_pll;
        end
    end

    // Count half periods and toggle the divided clock at terminal count.
    always_ff @(posedge div_clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (bypass_now) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (cnt_q == half_m1) begin
            cnt_q <= '0;
            if (tog_q) begin
                tog_q <= 1'b0;
            end else begin
                tog_q <= (log2_next != '0);
            end
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Record that the divider is out of reset.
    always_ff @(posedge div_clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    // Enable pass-through on the falling edge so that it changes while the clock is low.
    always_ff @(negedge div_clk) begin
        pass_q <= run_q && (log2_q == '0);
    end

    assign sel_pll  = sel_q;
    assign log2_app = log2_q;
    assign cnt      = cnt_q;
    assign tog      = tog_q;
    assign pass     = pass_q;

endmodule

// File: rtl/clkdiv_outpair.sv
// One output pair: a true line that picks either the pass-through clock or the
// toggle flop, plus its complement. Assumes pass changes only while div_clk is low.
module clkdiv_outpair (
    input  logic div_clk,
    input  logic tog,
    input  logic pass,
    output logic out_t,
    output logic out_c
);

    // Select the true line and derive its complement.
    always_comb begin
        out_t = pass ? div_clk : tog;
        out_c = ~out_t;
    end

endmodule

// File: rtl/clkdiv_sel.sv
// Top of the selectable clock divider: clock switch, divider engine and a
// generated set of mirrored output pairs (pair 0 main, pair 1 feedback copy).
// Assumes free-running source clocks and controls that are stable around
// rising edges of the selected clock.
module clkdiv_sel #(
    parameter int unsigned NUM_PAIRS = 2
) (
    input  logic       ref_clk,
    input  logic       pll_clk,
    input  logic       rst_n,
    input  logic       use_pll,
    input  logic [3:0] ratio_code,
    output logic       out_main,
    output logic       out_main_b,
    output logic       out_fb,
    output logic       out_fb_b
);

    localparam int unsigned LOG2_W = clkdiv_pkg::LOG2_W;
    localparam int unsigned CNT_W  = clkdiv_pkg::CNT_W;

    logic              div_clk;
    logic              ref_live;
    logic              pll_live;
    logic              sel_pll;
    logic [LOG2_W-1:0] log2_app;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  half_m1;
    logic              boundary;
    logic              tog;
    logic              pass;
    logic [NUM_PAIRS-1:0] pair_t;
    logic [NUM_PAIRS-1:0] pair_c;

    clkdiv_switch u_switch (
        .ref_clk  (ref_clk),
        .pll_clk  (pll_clk),
        .sel_pll  (sel_pll),
        .div_clk  (div_clk),
        .ref_live (ref_live),
        .pll_live (pll_live)
    );

    clkdiv_engine #(
        .CODE_W (4),
        .LOG2_W (LOG2_W),
        .CNT_W  (CNT_W)
    ) u_engine (
        .div_clk    (div_clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .use_pll    (use_pll),
        .sel_pll    (sel_pll),
        .log2_app   (log2_app),
        .cnt        (cnt),
        .half_m1    (half_m1),
        .boundary   (boundary),
        .tog        (tog),
        .pass       (pass)
    );

    for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
        clkdiv_outpair u_pair (
            .div_clk (div_clk),
            .tog     (tog),
            .pass    (pass),
            .out_t   (pair_t[gi]),
            .out_c   (pair_c[gi])
        );
    end

    assign out_main   = pair_t[0];
    assign out_main_b = pair_c[0];
    assign out_fb     = pair_t[NUM_PAIRS-1];
    assign out_fb_b   = pair_c[NUM_PAIRS-1];

endmodule

// File: rtl/clkdiv_sel_chk.sv
// Checker for clkdiv_sel, attached with bind. Observes the switch gates, the
// divider state and the output pairs.
module clkdiv_sel_chk #(
    parameter int unsigned LOG2_W = clkdiv_pkg::LOG2_W,
    parameter int unsigned CNT_W  = clkdiv_pkg::CNT_W
) (
    input logic              ref_clk,
    input logic              div_clk,
    input logic              rst_n,
    input logic              ref_live,
    input logic              pll_live,
    input logic [LOG2_W-1:0] log2_app,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  half_m1,
    input logic              boundary,
    input logic              tog,
    input logic              out_main,
    input logic              out_main_b,
    input logic              out_fb,
    input logic              out_fb_b
);

    // R9
    one_source_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(ref_live && pll_live));

    // R5
    mirror_chk: assert property (@(negedge div_clk) disable iff (!rst_n)
        (out_main == out_fb) && (out_main_b == out_fb_b));

    // R5
    complement_chk: assert property (@(negedge div_clk) disable iff (!rst_n)
        out_main_b == !out_main);

    // R6
    reset_clear_chk: assert property (@(posedge div_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0) && !tog);

    // R8
    ratio_hold_chk: assert property (@(posedge div_clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(boundary)) |-> $stable(log2_app));

    // R4
    toggle_at_term_chk: assert property (@(posedge div_clk) disable iff (!rst_n)
        ($past(rst_n) && (tog != $past(tog))) |-> ($past(cnt) == $past(half_m1)));

endmodule

bind clkdiv_sel clkdiv_sel_chk u_chk (
    .ref_clk    (ref_clk),
    .div_clk    (div_clk),
    .rst_n      (rst_n),
    .ref_live   (ref_live),
    .pll_live   (pll_live),
    .log2_app   (log2_app),
    .cnt        (cnt),
    .half_m1    (half_m1),
    .boundary   (boundary),
    .tog        (tog),
    .out_main   (out_main),
    .out_main_b (out_main_b),
    .out_fb     (out_fb),
    .out_fb_b   (out_fb_b)
);

// File: tb/clkdiv_sel_test.sv
`timescale 1ns/1ps
// Directed bench for clkdiv_sel: one task per scenario, each checking its own results.
module clkdiv_sel_test;

    localparam longint REF_P = 10;
    localparam longint PLL_P = 16;

    logic       ref_clk = 1'b0;
    logic       pll_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_pll = 1'b0;
    logic [3:0] ratio_code = 4'd0;
    logic       out_main, out_main_b, out_fb, out_fb_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int ratio_tab [16] = '{4, 4, 4, 8, 8, 8, 16, 16, 32, 64, 2, 2, 4, 1, 2, 1};

    clkdiv_sel uut (
        .ref_clk    (ref_clk),
        .pll_clk    (pll_clk),
        .rst_n      (rst_n),
        .use_pll    (use_pll),
        .ratio_code (ratio_code),
        .out_main   (out_main),
        .out_main_b (out_main_b),
        .out_fb     (out_fb),
        .out_fb_b   (out_fb_b)
    );

    always #5 ref_clk = ~ref_clk;
    always #8 pll_clk = ~pll_clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_mirror(input string req);
        check((out_main === out_fb) && (out_main_b === out_fb_b) && (out_main_b === ~out_main),
              req, {out_main, out_main_b, out_fb, out_fb_b}, {out_main, ~out_main, out_main, ~out_main});
    endtask

    // Measure one output period and its high time from rising edge to rising edge.
    task automatic measure(output longint per, output longint hi);
        longint t0, t1, t2;
        @(posedge out_main); t0 = $time;
        #1 check_mirror("R5");
        @(negedge out_main); t1 = $time;
        #1 check_mirror("R5");
        @(posedge out_main); t2 = $time;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic settle();
        repeat (3) @(posedge out_main);
    endtask

    // R6: levels held during reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (12) @(negedge ref_clk);
        for (int k = 0; k < 4; k++) begin
            #2;
            check(out_main === 1'b0 && out_fb === 1'b0, "R6 true low", {out_main, out_fb}, 0);
            check(out_main_b === 1'b1 && out_fb_b === 1'b1, "R6 compl high", {out_main_b, out_fb_b}, 3);
            @(negedge ref_clk);
        end
    endtask

    // R7: first rising edge after release, released at a reference falling edge.
    task automatic t_release(input logic [3:0] code);
        longint t_rel;
        longint exp_dt;
        use_pll = 1'b0;
        ratio_code = code;
        t_reset();
        @(negedge ref_clk);
        rst_n = 1'b1;
        t_rel = $time;
        @(posedge out_main);
        exp_dt = REF_P / 2 + (ratio_tab[code] / 2 - 1) * REF_P;
        check(($time - t_rel) == exp_dt, "R7 first rise", $time - t_rel, exp_dt);
    endtask

    // R2, R3, R4, R1: every code from the reference source.
    task automatic t_sweep_ref();
        longint per, hi;
        use_pll = 1'b0;
        for (int c = 0; c < 16; c++) begin
            @(negedge ref_clk);
            ratio_code = 4'(c);
            settle();
            measure(per, hi);
            check(per == ratio_tab[c] * REF_P, (ratio_tab[c] == 1) ? "R3 R2 R1 period" : "R2 R1 period",
                  per, ratio_tab[c] * REF_P);
            check(hi * 2 == per, (ratio_tab[c] == 1) ? "R3 high time" : "R4 duty", hi, per / 2);
        end
    endtask

    // R1, R9: move to the synthesizer source and back.
    task automatic t_source();
        longint per, hi;
        @(negedge ref_clk);
        ratio_code = 4'd3;
        settle();
        use_pll = 1'b1;
        settle();
        measure(per, hi);
        check(per == 8 * PLL_P, "R1 R9 pll period", per, 8 * PLL_P);
        check(hi == 4 * PLL_P, "R4 pll duty", hi, 4 * PLL_P);
        #3 ratio_code = 4'd13;
        settle();
        measure(per, hi);
        check(per == PLL_P, "R3 pll pass period", per, PLL_P);
        check(hi == PLL_P / 2, "R3 pll pass high", hi, PLL_P / 2);
        #3 use_pll = 1'b0;
        ratio_code = 4'd0;
        settle();
        measure(per, hi);
        check(per == 4 * REF_P, "R9 back to ref", per, 4 * REF_P);
    endtask

    // R8: a ratio change in a high phase lets that phase and the next low phase finish.
    task automatic t_midchange();
        longint t0, t1, t2, per, hi;
        use_pll = 1'b0;
        @(negedge ref_clk);
        ratio_code = 4'd9;
        settle();
        @(posedge out_main); t0 = $time;
        #52 ratio_code = 4'd10;
        @(negedge out_main); t1 = $time;
        check((t1 - t0) == 32 * REF_P, "R8 high kept", t1 - t0, 32 * REF_P);
        @(posedge out_main); t2 = $time;
        check((t2 - t1) == 32 * REF_P, "R8 low kept", t2 - t1, 32 * REF_P);
        measure(per, hi);
        check(per == 2 * REF_P, "R8 new ratio", per, 2 * REF_P);
    endtask

    initial begin
        t_reset();
        t_release(4'd0);
        t_release(4'd9);
        t_sweep_ref();
        t_source();
        t_midchange();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule